// File: doc/BRIEF.md
# Return-to-Zero Two-Line Serial Word Receiver

This block takes a bipolar return-to-zero serial line that a level converter has already split into two logic inputs. One input is high while the line is driven positive, which means a logic one. The other is high while the line is driven negative, which means a logic zero. Neither is high while the line rests at null. Each bit cell holds one pulse on exactly one of the two inputs, and the line returns to null before the next cell begins.

A word is always 32 bits long. There is no start bit and no sync pattern. Word boundaries come only from idle time: words are separated by at least four bit times of null. The receiver measures continuous null time with an oversampling system clock. It assembles the bits of each word into a parallel word and presents the finished word with a one-cycle strobe and an odd-parity flag. It also reports three kinds of framing fault as one-cycle error strobes.

A rate-select input chooses a fast or a slow line rate. The slow bit time is a fixed multiple of the fast one. The receiver may be switched on while a word is already in progress. In that case it drops the partial word and picks up alignment at the next inter-word gap.

Top module: `rz_word_rx`

## Requirements
- R1: Each raw input passes through a two-flop synchronizer and then a filter. A level change counts only after it has held for FILTER_CLKS consecutive clocks, so a pulse shorter than that has no effect on framing.
- R2: After reset, and after any error, the receiver accepts a first bit only if at least 4 bit times of continuous null came before that bit. Pulses that arrive earlier are ignored without an error.
- R3: Bits are stored in arrival order, with the first bit at bit 0 of word_data. After the 32nd bit, word_valid is high for exactly one clock, and word_data changes only in that clock.
- R4: In the clock where word_valid is high, parity_ok is 1 exactly when word_data holds an odd number of ones.
- R5: If null lasts 1.5 bit times or more while a word is incomplete, err_short pulses for one clock, the word is dropped (no word_valid), and the receiver returns to hunting (R2).
- R6: If both inputs are high at the same time while the receiver is enabled, err_line pulses for one clock, any partial word is dropped, and the receiver returns to hunting (R2).
- R7: A pulse that arrives after a completed word but before 4 bit times of null is ignored and raises err_gap for one clock. The receiver accepts a new word only after a full gap.
- R8: While enable is low, no strobe is raised. If the receiver is enabled partway through a word, that word produces no word_valid, and the next word after a gap is received correctly.
- R9: During reset and in the clock after it, word_valid, parity_ok, all error strobes and word_data are 0.
- R10: rate_slow=1 selects a bit time of FAST_BIT_CLKS*SLOW_FACTOR clocks. rate_slow=0 selects FAST_BIT_CLKS. Both gap thresholds and the mid-word timeout scale with the selected bit time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receiver enable; low forces hunting |
| rate_slow | input | 1 | 1 = slow line rate, 0 = fast line rate |
| line_one | input | 1 | High during a positive (logic one) pulse |
| line_zero | input | 1 | High during a negative (logic zero) pulse |
| word_data | output | WORD_BITS | Last completed word, first bit at bit 0 |
| word_valid | output | 1 | One-clock strobe for a new word |
| parity_ok | output | 1 | Odd parity over word_data, valid with word_valid |
| err_short | output | 1 | Strobe: word cut short by a long null |
| err_line | output | 1 | Strobe: both inputs high at once |
| err_gap | output | 1 | Strobe: pulse before the inter-word gap ended |

## Verification
The bound checker watches several properties on every cycle:
- word_valid never lasts two clocks.
- At most one result or error strobe fires in any clock.
- parity_ok matches the ones count of word_data.
- word_data moves only together with word_valid.
- A disabled receiver stays silent.
- Reset clears the outputs.

Correct framing needs whole stimulus scenarios, so only the bench can show it. These scenarios cover bit order under swept patterns at both rates, rejection of short glitches, the threshold of the hunt gap, aborts on long mid-word nulls, clashes, gap violations and realignment after a mid-word enable.

// File: rtl/rzrx_pkg.sv
package rzrx_pkg;

    localparam int WORD_BITS_DEF = 32;
    localparam int GAP_BITS      = 4;

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_RECV     = 2'd1,
        ST_WAIT_GAP = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        LVL_NULL = 2'd0,
        LVL_ZERO = 2'd1,
        LVL_ONE  = 2'd2,
        LVL_BOTH = 2'd3
    } line_lvl_e;

    typedef struct packed {
        logic short_err;
        logic line_err;
        logic gap_err;
    } rx_err_t;

    function automatic line_lvl_e line_level(input logic one_hi, input logic zero_hi);
        line_lvl_e lvl;
        unique case ({one_hi, zero_hi})
            2'b00:   lvl = LVL_NULL;
            2'b01:   lvl = LVL_ZERO;
            2'b10:   lvl = LVL_ONE;
            default: lvl = LVL_BOTH;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rzrx_deglitch.sv
module rzrx_deglitch #(
    parameter int STABLE_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic filt_out
);
    localparam int CW = (STABLE_CLKS < 2) ? 1 : $clog2(STABLE_CLKS);
    localparam logic [CW-1:0] RUN_LAST = CW'(STABLE_CLKS - 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            filt_q <= 1'b0;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], raw_in};
            if (sync_q[1] == filt_q) begin
                run_q <= '0;
            end else if (run_q == RUN_LAST) begin
                filt_q <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign filt_out = filt_q;
endmodule

// File: rtl/rzrx_edge_class.sv
module rzrx_edge_class
    import rzrx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic filt_one,
    input  logic filt_zero,
    output logic bit_strobe,
    output logic bit_value,
    output logic clash_strobe,
    output logic line_null
);
    logic      prev_one_q;
    logic      prev_zero_q;
    line_lvl_e lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_one_q  <= 1'b0;
            prev_zero_q <= 1'b0;
        end else begin
            prev_one_q  <= filt_one;
            prev_zero_q <= filt_zero;
        end
    end

    always_comb begin
        lvl          = line_level(filt_one, filt_zero);
        bit_strobe   = ((lvl == LVL_ONE)  && !prev_one_q) ||
                       ((lvl == LVL_ZERO) && !prev_zero_q);
        bit_value    = (lvl == LVL_ONE);
        clash_strobe = (lvl == LVL_BOTH) && !(prev_one_q && prev_zero_q);
        line_null    = (lvl == LVL_NULL);
    end
endmodule

// File: rtl/rzrx_null_timer.sv
module rzrx_null_timer
    import rzrx_pkg::*;
#(
    parameter int FAST_BIT_CLKS = 500,
    parameter int SLOW_FACTOR   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_slow,
    input  logic line_null,
    output logic gap_ok,
    output logic overlong
);
    localparam int SLOW_BIT_CLKS = FAST_BIT_CLKS * SLOW_FACTOR;
    localparam int SAT_CLKS      = GAP_BITS * SLOW_BIT_CLKS;
    localparam int CW            = $clog2(SAT_CLKS + 1);

    localparam logic [CW-1:0] SAT_V       = CW'(SAT_CLKS);
    localparam logic [CW-1:0] GAP_FAST    = CW'(GAP_BITS * FAST_BIT_CLKS);
    localparam logic [CW-1:0] GAP_SLOW    = CW'(GAP_BITS * SLOW_BIT_CLKS);
    localparam logic [CW-1:0] ABORT_FAST  = CW'(FAST_BIT_CLKS + FAST_BIT_CLKS / 2);
    localparam logic [CW-1:0] ABORT_SLOW  = CW'(SLOW_BIT_CLKS + SLOW_BIT_CLKS / 2);

    logic [CW-1:0] null_q;
    logic [CW-1:0] gap_thr;
    logic [CW-1:0] abort_thr;

    always_ff @(posedge clk) begin
        if (rst) begin
            null_q <= '0;
        end else if (!line_null) begin
            null_q <= '0;
        end else if (null_q != SAT_V) begin
            null_q <= null_q + 1'b1;
        end
    end

    always_comb begin
        gap_thr   = rate_slow ? GAP_SLOW   : GAP_FAST;
        abort_thr = rate_slow ? ABORT_SLOW : ABORT_FAST;
        gap_ok    = (null_q >= gap_thr);
        overlong  = (null_q >= abort_thr);
    end
endmodule

// File: rtl/rzrx_framer.sv
module rzrx_framer
    import rzrx_pkg::*;
#(
    parameter int WORD_BITS = WORD_BITS_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 bit_strobe,
    input  logic                 bit_value,
    input  logic                 clash_strobe,
    input  logic                 gap_ok,
    input  logic                 overlong,
    output logic [WORD_BITS-1:0] word_q,
    output logic                 valid_q,
    output logic                 parity_q,
    output rx_err_t              err_q
);
    localparam int CNT_W = $clog2(WORD_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);

    rx_state_e            st_q, st_d;
    logic [WORD_BITS-1:0] sh_q, sh_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic                 done;
    rx_err_t              err_d;

    always_comb begin
        st_d  = st_q;
        sh_d  = sh_q;
        cnt_d = cnt_q;
        done  = 1'b0;
        err_d = '0;
        if (!enable) begin
            st_d = ST_HUNT;
        end else if (clash_strobe) begin
            err_d.line_err = 1'b1;
            st_d           = ST_HUNT;
        end else begin
            unique case (st_q)
                ST_HUNT: begin
                    if (bit_strobe && gap_ok) begin
                        sh_d  = {bit_value, {(WORD_BITS-1){1'b0}}};
                        cnt_d = CNT_W'(1);
                        st_d  = ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (bit_strobe) begin
                        sh_d  = {bit_value, sh_q[WORD_BITS-1:1]};
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == LAST_IDX) begin
                            done = 1'b1;
                            st_d = ST_WAIT_GAP;
                        end
                    end else if (overlong) begin
                        err_d.short_err = 1'b1;
                        st_d            = ST_HUNT;
                    end
                end
                ST_WAIT_GAP: begin
                    if (bit_strobe) begin
                        if (gap_ok) begin
                            sh_d  = {bit_value, {(WORD_BITS-1){1'b0}}};
                            cnt_d = CNT_W'(1);
                            st_d  = ST_RECV;
                        end else begin
                            err_d.gap_err = 1'b1;
                        end
                    end
                end
                default: st_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_HUNT;
            sh_q     <= '0;
            cnt_q    <= '0;
            word_q   <= '0;
            valid_q  <= 1'b0;
            parity_q <= 1'b0;
            err_q    <= '0;
        end else begin
            st_q    <= st_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
            valid_q <= done;
            err_q   <= err_d;
            if (done) begin
                word_q   <= sh_d;
                parity_q <= ^sh_d;
            end else begin
                parity_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rz_word_rx.sv
module rz_word_rx
    import rzrx_pkg::*;
#(
    parameter int WORD_BITS     = WORD_BITS_DEF,
    parameter int FAST_BIT_CLKS = 500,
    parameter int SLOW_FACTOR   = 8,
    parameter int FILTER_CLKS   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 rate_slow,
    input  logic                 line_one,
    input  logic                 line_zero,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_valid,
    output logic                 parity_ok,
    output logic                 err_short,
    output logic                 err_line,
    output logic                 err_gap
);
    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    logic       bit_strobe, bit_value, clash_strobe, line_null;
    logic       gap_ok, overlong;
    rx_err_t    errs;

    assign raw_lines = {line_one, line_zero};

    for (genvar g = 0; g < 2; g++) begin : g_line
        rzrx_deglitch #(.STABLE_CLKS(FILTER_CLKS)) u_dg (
            .clk     (clk),
            .rst     (rst),
            .raw_in  (raw_lines[g]),
            .filt_out(filt_lines[g])
        );
    end

    rzrx_edge_class u_edge (
        .clk         (clk),
        .rst         (rst),
        .filt_one    (filt_lines[1]),
        .filt_zero   (filt_lines[0]),
        .bit_strobe  (bit_strobe),
        .bit_value   (bit_value),
        .clash_strobe(clash_strobe),
        .line_null   (line_null)
    );

    rzrx_null_timer #(
        .FAST_BIT_CLKS(FAST_BIT_CLKS),
        .SLOW_FACTOR  (SLOW_FACTOR)
    ) u_null (
        .clk      (clk),
        .rst      (rst),
        .rate_slow(rate_slow),
        .line_null(line_null),
        .gap_ok   (gap_ok),
        .overlong (overlong)
    );

    rzrx_framer #(.WORD_BITS(WORD_BITS)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .bit_strobe  (bit_strobe),
        .bit_value   (bit_value),
        .clash_strobe(clash_strobe),
        .gap_ok      (gap_ok),
        .overlong    (overlong),
        .word_q      (word_data),
        .valid_q     (word_valid),
        .parity_q    (parity_ok),
        .err_q       (errs)
    );

    assign err_short = errs.short_err;
    assign err_line  = errs.line_err;
    assign err_gap   = errs.gap_err;
endmodule

// File: rtl/rzrx_checks.sv
module rzrx_checks #(
    parameter int WORD_BITS = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 enable,
    input logic [WORD_BITS-1:0] word_data,
    input logic                 word_valid,
    input logic                 parity_ok,
    input logic                 err_short,
    input logic                 err_line,
    input logic                 err_gap
);
    p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    p_data_moves_with_valid_r3: assert property (@(posedge clk) disable iff (rst)
        (word_data != $past(word_data)) |-> word_valid);

    p_parity_odd_r4: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (parity_ok == (($countones(word_data) % 2) == 1)));

    // R5, R6, R7: one outcome per clock
    p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({word_valid, err_short, err_line, err_gap}));

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !(word_valid || err_short || err_line || err_gap));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!word_valid && !parity_ok && !err_short && !err_line &&
                 !err_gap && (word_data == '0)));
endmodule

bind rz_word_rx rzrx_checks #(.WORD_BITS(WORD_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .word_data (word_data),
    .word_valid(word_valid),
    .parity_ok (parity_ok),
    .err_short (err_short),
    .err_line  (err_line),
    .err_gap   (err_gap)
);

// File: tb/rz_word_rx_tb_top.sv
module rz_word_rx_tb_top;
    localparam int FAST    = 16;
    localparam int SLOWF   = 8;
    localparam int FILT    = 3;
    localparam int WB      = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b1;
    logic rate_slow = 1'b0;
    logic line_one = 1'b0;
    logic line_zero = 1'b0;
    logic [WB-1:0] word_data;
    logic word_valid, parity_ok, err_short, err_line, err_gap;

    int n_checks = 0, n_fail = 0;
    int valid_cnt = 0, short_cnt = 0, line_cnt = 0, gap_cnt = 0;
    logic [WB-1:0] last_word = '0;
    logic last_par = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rz_word_rx #(
        .WORD_BITS(WB), .FAST_BIT_CLKS(FAST), .SLOW_FACTOR(SLOWF), .FILTER_CLKS(FILT)
    ) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .rate_slow(rate_slow),
        .line_one(line_one), .line_zero(line_zero), .word_data(word_data),
        .word_valid(word_valid), .parity_ok(parity_ok), .err_short(err_short),
        .err_line(err_line), .err_gap(err_gap)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (word_valid) begin
                valid_cnt++;
                last_word = word_data;
                last_par  = parity_ok;
            end
            if (err_short) short_cnt++;
            if (err_line)  line_cnt++;
            if (err_gap)   gap_cnt++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [WB-1:0] act, input logic [WB-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic odd_ones(input logic [WB-1:0] w);
        int c = 0;
        for (int i = 0; i < WB; i++) c += int'(w[i]);
        return logic'(c % 2);
    endfunction

    function automatic int bit_clks();
        return rate_slow ? FAST * SLOWF : FAST;
    endfunction

    task automatic idle_clks(input int n);
        line_one  = 1'b0;
        line_zero = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        int bt = bit_clks();
        @(negedge clk);
        line_one  = b;
        line_zero = ~b;
        repeat (bt / 2 - 1) @(negedge clk);
        idle_clks(bt - bt / 2);
    endtask

    task automatic send_bits(input logic [WB-1:0] w, input int first, input int last);
        for (int i = first; i <= last; i++) send_bit(w[i]);
    endtask

    task automatic good_word(input string req, input logic [WB-1:0] w);
        int v0 = valid_cnt, e0 = short_cnt + line_cnt + gap_cnt;
        send_bits(w, 0, WB - 1);
        idle_clks(5 * bit_clks());
        chk(req, "word count", WB'(valid_cnt - v0), WB'(1));
        chk(req, "word data", last_word, w);
        chk("R4", "parity", WB'(last_par), WB'(odd_ones(w)));
        chk(req, "no error", WB'(short_cnt + line_cnt + gap_cnt - e0), WB'(0));
    endtask

    initial begin
        int v0, c0;
        repeat (5) @(negedge clk);
        chk("R9", "valid in reset", WB'(word_valid), WB'(0));
        chk("R9", "data in reset", word_data, WB'(0));
        chk("R9", "errors in reset", WB'({parity_ok, err_short, err_line, err_gap}), WB'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "valid after reset", WB'(word_valid), WB'(0));
        chk("R9", "data after reset", word_data, WB'(0));

        // R2: word right after reset has no preceding gap
        v0 = valid_cnt;
        send_bits(32'hA5A5_0F0F, 0, WB - 1);
        idle_clks(5 * FAST);
        chk("R2", "word without gap after reset", WB'(valid_cnt - v0), WB'(0));

        // R3/R4: walking-one sweep, fast rate
        for (int i = 0; i < WB; i++) good_word("R3", WB'(1) << i);
        // R4: even-weight patterns
        for (int i = 0; i < WB - 1; i += 3) good_word("R4", (WB'(3) << i));
        good_word("R4", '1);
        good_word("R3", '0);
        good_word("R3", 32'h1234_5678);

        // R10: slow rate words
        rate_slow = 1'b1;
        idle_clks(5 * FAST * SLOWF);
        good_word("R10", 32'hDEAD_BEEF);
        good_word("R10", 32'h8000_0001);
        // R10: a fast-sized gap is not a gap at the slow rate
        c0 = gap_cnt;
        send_bits(32'h0000_FFFF, 0, WB - 1);
        idle_clks(5 * FAST);
        send_bit(1'b1);
        idle_clks(5 * FAST * SLOWF);
        chk("R10", "fast-sized gap rejected at slow rate", WB'(gap_cnt - c0), WB'(1));
        rate_slow = 1'b0;
        idle_clks(5 * FAST);

        // R1: glitch inside a gap is filtered
        c0 = gap_cnt;
        send_bits(32'h0F0F_0F0F, 0, WB - 1);
        idle_clks(FAST);
        line_one = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        idle_clks(5 * FAST);
        chk("R1", "short glitch ignored", WB'(gap_cnt - c0), WB'(0));
        good_word("R1", 32'hF0F0_1111);

        // R5: short word
        v0 = valid_cnt; c0 = short_cnt;
        send_bits(32'h5555_AAAA, 0, 19);
        idle_clks(5 * FAST);
        chk("R5", "short error", WB'(short_cnt - c0), WB'(1));
        chk("R5", "no word", WB'(valid_cnt - v0), WB'(0));
        good_word("R5", 32'h0000_00C3);

        // R6: clash mid-word
        v0 = valid_cnt; c0 = line_cnt;
        send_bits(32'h7777_7777, 0, 7);
        @(negedge clk);
        line_one = 1'b1; line_zero = 1'b1;
        repeat (FAST / 2 - 1) @(negedge clk);
        idle_clks(FAST - FAST / 2);
        send_bits(32'h7777_7777, 9, WB - 1);
        idle_clks(FAST / 2);
        chk("R6", "line error", WB'(line_cnt - c0), WB'(1));
        chk("R6", "word dropped", WB'(valid_cnt - v0), WB'(0));
        idle_clks(5 * FAST);
        good_word("R6", 32'hCAFE_0001);

        // R2: after an error, 3 bit times of null is not enough
        v0 = valid_cnt;
        @(negedge clk);
        line_one = 1'b1; line_zero = 1'b1;
        repeat (FAST / 2) @(negedge clk);
        idle_clks(3 * FAST);
        send_bits(32'h0101_0101, 0, WB - 1);
        idle_clks(5 * FAST);
        chk("R2", "3-bit gap refused in hunt", WB'(valid_cnt - v0), WB'(0));
        good_word("R2", 32'h0101_0101);

        // R7: gap violation
        v0 = valid_cnt; c0 = gap_cnt;
        send_bits(32'h3C3C_3C3C, 0, WB - 1);
        idle_clks(FAST);
        send_bit(1'b0);
        send_bit(1'b1);
        idle_clks(5 * FAST);
        chk("R7", "gap errors", WB'(gap_cnt - c0), WB'(2));
        chk("R7", "only first word", WB'(valid_cnt - v0), WB'(1));
        good_word("R7", 32'h9999_0000);

        // R8: enable arrives mid-word
        v0 = valid_cnt;
        enable = 1'b0;
        send_bits(32'hFEDC_BA98, 0, 9);
        enable = 1'b1;
        send_bits(32'hFEDC_BA98, 10, WB - 1);
        idle_clks(5 * FAST);
        chk("R8", "mid-word enable gives no word", WB'(valid_cnt - v0), WB'(0));
        good_word("R8", 32'hFEDC_BA98);
        // R8: disabled for a whole word
        v0 = valid_cnt;
        enable = 1'b0;
        good_word_off: begin
            send_bits(32'h1111_2222, 0, WB - 1);
            idle_clks(5 * FAST);
        end
        chk("R8", "disabled word ignored", WB'(valid_cnt - v0), WB'(0));
        enable = 1'b1;
        good_word("R8", 32'h2222_1111);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule